// File: doc/BRIEF.md
# Write Status Read Responder

This block sits in the read path of a byte-wide non-volatile memory. It lets a host find out by polling when an internal write cycle is done. While the memory is idle, a host read returns the array byte for the read address. While an internal write cycle is running, the same read returns a status byte instead.

The status byte carries three completion indicators at fixed bit positions:

- **Bit 7, polling bit.** Holds the inverse of bit 7 of the byte that was last latched for writing.
- **Bit 6, toggle bit.** Alternates on every status read.
- **Bit 5, page-load timer status.** Shows the state of the page-load timer.

The remaining low bits are not driven during a status read. Undriven bits are reported through a per-bit drive-enable mask, not through tristate signals.

The block takes these inputs:

- a single-cycle read strobe and the read address;
- the address of the last latched byte and bit 7 of that byte;
- the busy flag of the programming sequencer;
- the page-load timer time-out flag;
- the array data for the current read address.

Each strobed read produces a registered response one clock later, with a valid flag and the drive mask.

Top module: `wrstat_rsp`

## Requirements
- R1: After reset, respValid is 0, respDrive is 8'h00 and respData is 8'h00 until the first strobed read.
- R2: A read with busy low returns, one cycle later, respValid=1, respData equal to arrayData as sampled with the strobe, and respDrive=8'hFF.
- R3: A read with busy high whose address equals lastAddr returns bit 7 as the inverse of lastBit7, with respDrive bit 7 set to 1.
- R4: A read with busy high at any other address leaves bit 7 undriven: respDrive bit 7 is 0 and respData bit 7 is 0.
- R5: During one busy period, bit 6 of successive status reads alternates, and the first status read of the period returns 0. Bit 6 is always driven during a status read.
- R6: The toggle state restarts at 0 whenever busy goes from low to high, even if the previous busy period ended on a status read that returned 1. A status read in the very cycle busy rises also returns 0.
- R7: During a status read, bit 5 equals timerDone as sampled with the strobe (0 means the timer is running, 1 means it has expired), and bit 5 is driven.
- R8: During a status read, bits 4 down to 0 are undriven: respDrive[4:0]=0 and respData[4:0]=0.
- R9: A cycle with no read strobe gives, one cycle later, respValid=0, respDrive=8'h00 and respData=8'h00.
- R10: Once busy has returned low, reads return the true array byte including bit 7, and the toggling bit no longer appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rdStb | input | 1 | Single-cycle read request |
| rdAddr | input | ADDR_W | Address being read |
| arrayData | input | 8 | Array byte for rdAddr, valid with rdStb |
| lastAddr | input | ADDR_W | Address of the last latched write byte |
| lastBit7 | input | 1 | Bit 7 of the last latched write byte |
| busy | input | 1 | Internal write cycle in progress |
| timerDone | input | 1 | Page-load timer has expired |
| respValid | output | 1 | Response present this cycle |
| respData | output | 8 | Read response byte |
| respDrive | output | 8 | Per-bit drive enable of respData |

## Verification
Every response is due exactly one clock after the cycle whose inputs produced it, because the only register on the path is the output stage. The bench changes inputs on the falling edge and compares the outputs on the next falling edge, after the one rising edge that captured them. The toggle state is the only state that spans several reads. The bench keeps its own copy of that state, reset on each busy rise and flipped on each status read, so expectations for runs of reads across several busy periods come from the requirements alone.

// File: rtl/wrstat_pkg.sv
package wrstat_pkg;
  localparam int DATA_W    = 8;
  localparam int POLL_BIT  = 7;
  localparam int TOG_BIT   = 6;
  localparam int TMR_BIT   = 5;

  typedef struct packed {
    logic load;     // a read was strobed this cycle
    logic status;   // the read is answered with status
    logic pollHit;  // read address matches the last latched address
    logic togVal;   // toggle value presented for this read
  } strobe_t;
endpackage

// File: rtl/wrstat_ctrl.sv
module wrstat_ctrl
  import wrstat_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] lastAddr,
  input  logic              busy,
  output strobe_t           stb
);
  logic busyQ;
  logic togQ;
  logic busyRise;
  logic togCur;

  assign busyRise = busy & ~busyQ;
  // a fresh busy period always starts from 0
  assign togCur   = busyRise ? 1'b0 : togQ;

  always_comb begin
    stb.load    = rdStb;
    stb.status  = rdStb & busy;
    stb.pollHit = (rdAddr == lastAddr);
    stb.togVal  = togCur;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyQ <= 1'b0;
      togQ  <= 1'b0;
    end else begin
      busyQ <= busy;
      if (stb.status)  togQ <= ~togCur;
      else if (busyRise) togQ <= 1'b0;
    end
  end
endmodule

// File: rtl/wrstat_dp.sv
module wrstat_dp
  import wrstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              lastBit7,
  input  logic              timerDone,
  output logic              respValid,
  output logic [DATA_W-1:0] respData,
  output logic [DATA_W-1:0] respDrive
);
  logic [DATA_W-1:0] dataNxt;
  logic [DATA_W-1:0] driveNxt;

  always_comb begin
    dataNxt  = '0;
    driveNxt = '0;
    if (stb.load) begin
      if (!stb.status) begin
        dataNxt  = arrayData;
        driveNxt = '1;
      end else begin
        dataNxt[POLL_BIT]  = stb.pollHit & ~lastBit7;
        driveNxt[POLL_BIT] = stb.pollHit;
        dataNxt[TOG_BIT]   = stb.togVal;
        driveNxt[TOG_BIT]  = 1'b1;
        dataNxt[TMR_BIT]   = timerDone;
        driveNxt[TMR_BIT]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      respValid <= 1'b0;
      respData  <= '0;
      respDrive <= '0;
    end else begin
      respValid <= stb.load;
      respData  <= dataNxt;
      respDrive <= driveNxt;
    end
  end
endmodule

// File: rtl/wrstat_rsp.sv
module wrstat_rsp
  import wrstat_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        arrayData,
  input  logic [ADDR_W-1:0] lastAddr,
  input  logic              lastBit7,
  input  logic              busy,
  input  logic              timerDone,
  output logic              respValid,
  output logic [7:0]        respData,
  output logic [7:0]        respDrive
);
  strobe_t stb;

  wrstat_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .rdStb(rdStb), .rdAddr(rdAddr),
    .lastAddr(lastAddr), .busy(busy), .stb(stb)
  );

  wrstat_dp dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .arrayData(arrayData),
    .lastBit7(lastBit7), .timerDone(timerDone),
    .respValid(respValid), .respData(respData), .respDrive(respDrive)
  );
endmodule

// File: rtl/wrstat_chk.sv
module wrstat_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rdStb,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [7:0]        arrayData,
  input logic [ADDR_W-1:0] lastAddr,
  input logic              lastBit7,
  input logic              busy,
  input logic              timerDone,
  input logic              respValid,
  input logic [7:0]        respData,
  input logic [7:0]        respDrive
);
  // R2
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStb && !busy) |=> (respValid && respDrive == 8'hFF && respData == $past(arrayData)));

  // R9
  no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdStb |=> (!respValid && respDrive == 8'h00 && respData == 8'h00));

  // R3
  poll_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStb && busy && rdAddr == lastAddr) |=> (respDrive[7] && respData[7] == !$past(lastBit7)));

  // R4
  poll_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStb && busy && rdAddr != lastAddr) |=> (!respDrive[7] && !respData[7]));

  // R7
  timer_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStb && busy) |=> (respDrive[5] && respData[5] == $past(timerDone)));

  // R8
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStb && busy) |=> (respDrive[4:0] == 5'd0 && respData[4:0] == 5'd0));

  // R6
  tog_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStb && $rose(busy)) |=> (respDrive[6] && !respData[6]));
endmodule

bind wrstat_rsp wrstat_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rdStb(rdStb), .rdAddr(rdAddr),
  .arrayData(arrayData), .lastAddr(lastAddr), .lastBit7(lastBit7),
  .busy(busy), .timerDone(timerDone), .respValid(respValid),
  .respData(respData), .respDrive(respDrive)
);

// File: tb/wrstat_rsp_tb.sv
`timescale 1ns/1ps
module wrstat_rsp_tb_top;
  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rdStb = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [7:0]    arrayData;
  logic [AW-1:0] lastAddr = '0;
  logic          lastBit7 = 1'b0;
  logic          busy = 1'b0;
  logic          timerDone = 1'b0;
  logic          respValid;
  logic [7:0]    respData;
  logic [7:0]    respDrive;

  int checks = 0;
  int fails = 0;
  bit tbTog = 1'b0;
  bit prevBusy = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] memOf(input logic [AW-1:0] a);
    memOf = a[7:0] ^ {a[10:8], 5'b10110} ^ 8'h5A;
  endfunction
  assign arrayData = memOf(rdAddr);

  wrstat_rsp #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rdStb(rdStb), .rdAddr(rdAddr),
    .arrayData(arrayData), .lastAddr(lastAddr), .lastBit7(lastBit7),
    .busy(busy), .timerDone(timerDone), .respValid(respValid),
    .respData(respData), .respDrive(respDrive)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: apply at negedge, compare at the next negedge
  task automatic step(input bit s, input bit b, input logic [AW-1:0] a, input bit t);
    bit rise, tog, hit;
    logic [7:0] expMem;
    rdStb = s; busy = b; rdAddr = a; timerDone = t;
    expMem = memOf(a);
    rise = b && !prevBusy;
    tog = rise ? 1'b0 : tbTog;
    hit = (a == lastAddr);
    if (s && b) tbTog = ~tog;
    else if (rise) tbTog = 1'b0;
    prevBusy = b;
    @(negedge clk);
    if (!s) begin
      chk("R9 idle cycle", {7'd0, respValid, respDrive}, 16'h0000);
      chk("R9 data", {8'd0, respData}, 16'h0000);
    end else if (!b) begin
      chk("R2 valid/drive", {7'd0, respValid, respDrive}, {7'd0, 1'b1, 8'hFF});
      chk("R2/R10 data", {8'd0, respData}, {8'd0, expMem});
    end else begin
      if (hit) chk("R3 poll bit", {14'd0, respDrive[7], respData[7]}, {14'd0, 1'b1, ~lastBit7});
      else     chk("R4 poll undriven", {14'd0, respDrive[7], respData[7]}, 16'd0);
      chk(rise ? "R6 toggle restart" : "R5 toggle bit",
          {14'd0, respDrive[6], respData[6]}, {14'd0, 1'b1, tog});
      chk("R7 timer bit", {14'd0, respDrive[5], respData[5]}, {14'd0, 1'b1, t});
      chk("R8 low bits", {6'd0, respDrive[4:0], respData[4:0]}, 16'd0);
      chk("R5 valid", {15'd0, respValid}, 16'd1);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs held clear through reset
    chk("R1 reset", {7'd0, respValid, respDrive}, 16'h0000);
    chk("R1 reset data", {8'd0, respData}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {respData, respDrive}, 16'h0000);

    // R2: sweep idle reads across the whole address space, stepping 7
    for (int i = 0; i < 2048; i += 7) step(1'b1, 1'b0, i[AW-1:0], i[0]);
    step(1'b0, 1'b0, 11'h000, 1'b0);

    // busy periods with differing last bytes and read patterns
    for (int p = 0; p < 6; p++) begin
      lastAddr = 11'(13 * p + 100);
      lastBit7 = p[0];
      // R6: a read in the very cycle busy rises
      step(1'b1, 1'b1, lastAddr, 1'b0);
      for (int k = 0; k < 3 + p; k++) begin
        bit useHit;
        useHit = ((k + p) % 3) != 0;
        step(1'b1, 1'b1, useHit ? lastAddr : 11'(lastAddr + k + 1), (k > 2));
        if (k == p) step(1'b0, 1'b1, lastAddr, 1'b0);
      end
      // R10: back to normal data after busy falls
      step(1'b1, 1'b0, lastAddr, 1'b1);
      step(1'b1, 1'b0, 11'(lastAddr + 1), 1'b0);
      step(1'b0, 1'b0, lastAddr, 1'b0);
      // busy rises without a read, then reads start (R6)
      if (p > 2) begin
        step(1'b0, 1'b1, lastAddr, 1'b0);
        step(1'b1, 1'b1, lastAddr, 1'b1);
        step(1'b1, 1'b1, lastAddr, 1'b1);
        step(1'b0, 1'b0, lastAddr, 1'b0);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule